// File: doc/BRIEF.md
# Protected clock-select control register

This block is the 8-bit control register that a microcontroller clock unit uses to pick its system clock source and to set how the oscillator and the low-power timers behave during stop. Software reaches it through a plain write strobe with write data, and it reads the current value back at any time on a read-data bus. Each control bit is also driven out on its own pin, so the clock multiplexer and the stop logic nearby can use it directly.

Three things decide whether a write takes effect. The first is a guard input that blocks all writes. The second is the operating mode: special mode or normal mode. The third is a sticky lock that engages when the watchdog configuration register is first written. The oscillator-ready status and the entry into full stop also act on the register. They can force the PLL selection on and clear the watchdog clock-source bit, whatever software writes in that cycle.

Top module: `clk_sel_ctrl`

## Requirements
- R1: After a synchronous reset the register reads 0x80: the PLL is selected and every other bit is 0.
- R2: Bit positions are: bit 7 PLL select, bit 6 keep-oscillator-in-stop, bit 3 timer-A-in-stop option, bit 2 watchdog-in-stop option, bit 1 timer-A source is oscillator, bit 0 watchdog source is oscillator. Bits 5 and 4 always read 0, even after a write of 1.
- R3: While `wr_guard` is 1, a write changes no bit.
- R4: A write of 0 to bit 7 clears it only when `osc_ready` is 1. Otherwise bit 7 stays 1.
- R5: In normal mode (`special_mode`=0), bits 7, 6, 3, 2 and 1 are writable at any time. Bit 0 is writable only while the watchdog lock is clear. A `wdog_cfg_wr` pulse sets the lock.
- R6: In special mode every implemented bit is writable, whatever the state of the watchdog lock, as long as `wr_guard` is 0.
- R7: While `osc_ready` is 0, hardware sets bit 7 and clears bit 0 on each clock edge. If bit 0 was 1 when it was cleared, the watchdog lock is released, so bit 0 can be written again in normal mode.
- R8: A `stop_entry` pulse while bit 6 is 0 (full stop) sets bit 7 and clears bit 0 on that edge. If bit 0 was 1, the lock is released. A `stop_entry` pulse while bit 6 is 1 forces nothing.
- R9: When a hardware force and a software write fall in the same cycle, the hardware value wins on bits 7 and 0. The write still updates bits 6 to 1.
- R10: Each output pin equals its register bit at all times, and `rd_data` equals the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| wr_guard | input | 1 | Blocks all writes when 1 |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| stop_entry | input | 1 | One-cycle pulse on entry to stop |
| osc_ready | input | 1 | Oscillator clock is stable |
| wdog_cfg_wr | input | 1 | Pulse on a write to the watchdog configuration |
| rd_data | output | 8 | Current register value |
| sel_pll | output | 1 | System clock from the PLL (1) or from the oscillator (0) |
| stop_osc_on | output | 1 | Oscillator keeps running in stop |
| opt_tmra_stop | output | 1 | Timer A allowed to run in stop |
| opt_wdog_stop | output | 1 | Watchdog allowed to run in stop |
| tmra_src_osc | output | 1 | Timer A clocked from the oscillator |
| wdog_src_osc | output | 1 | Watchdog clocked from the oscillator |

## Verification
The assertions check four rules on every cycle:
- the unused bits read zero;
- a low oscillator status forces PLL selection and clears the watchdog source bit;
- full-stop entry does the same;
- a guarded write, or a locked bit 0 in normal mode, leaves the register unchanged.

Other behaviours need the bench's ordered scenarios. These are the lock being released by a hardware clear and bit 0 then becoming writable again, the special-mode bypass of the lock, and a same-cycle write racing a force. The bench compares every cycle against its own model of the register and the lock.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
    localparam int REG_W     = 8;
    localparam int B_PLL     = 7;
    localparam int B_STOPOSC = 6;
    localparam int B_TMRA_ST = 3;
    localparam int B_WDOG_ST = 2;
    localparam int B_TMRA_SR = 1;
    localparam int B_WDOG_SR = 0;
    localparam logic [REG_W-1:0] RESET_BYTE = 8'h80;

    typedef struct packed {
        logic sel_pll;
        logic stop_osc_on;
        logic opt_tmra_stop;
        logic opt_wdog_stop;
        logic tmra_src_osc;
        logic wdog_src_osc;
    } ctl_t;

    typedef struct packed {
        logic any_ok;
        logic wdog_src_ok;
    } perm_t;

    typedef struct packed {
        logic force_pll;
        logic clear_wdog_src;
        logic release_lock;
    } hwf_t;

    function automatic logic [REG_W-1:0] ctl_to_byte(input ctl_t c);
        logic [REG_W-1:0] b;
        b = '0;
        b[B_PLL]     = c.sel_pll;
        b[B_STOPOSC] = c.stop_osc_on;
        b[B_TMRA_ST] = c.opt_tmra_stop;
        b[B_WDOG_ST] = c.opt_wdog_stop;
        b[B_TMRA_SR] = c.tmra_src_osc;
        b[B_WDOG_SR] = c.wdog_src_osc;
        return b;
    endfunction

    function automatic ctl_t byte_to_ctl(input logic [REG_W-1:0] b);
        ctl_t c;
        c.sel_pll       = b[B_PLL];
        c.stop_osc_on   = b[B_STOPOSC];
        c.opt_tmra_stop = b[B_TMRA_ST];
        c.opt_wdog_stop = b[B_WDOG_ST];
        c.tmra_src_osc  = b[B_TMRA_SR];
        c.wdog_src_osc  = b[B_WDOG_SR];
        return c;
    endfunction
endpackage

// File: rtl/clk_sel_wr_perm.sv
module clk_sel_wr_perm
    import clk_sel_pkg::*;
(
    input  logic  wr_en,
    input  logic  wr_guard,
    input  logic  special_mode,
    input  logic  locked,
    output perm_t perm
);
    always_comb begin
        perm.any_ok      = wr_en & ~wr_guard;
        perm.wdog_src_ok = wr_en & ~wr_guard & (special_mode | ~locked);
    end
endmodule

// File: rtl/clk_sel_hw_force.sv
module clk_sel_hw_force
    import clk_sel_pkg::*;
(
    input  logic osc_ready,
    input  logic stop_entry,
    input  logic stop_osc_on,
    input  logic wdog_src_now,
    output hwf_t hwf
);
    logic full_stop;
    logic down;

    always_comb begin
        full_stop          = stop_entry & ~stop_osc_on;
        down               = ~osc_ready | full_stop;
        hwf.force_pll      = down;
        hwf.clear_wdog_src = down;
        hwf.release_lock   = down & wdog_src_now;
    end
endmodule

// File: rtl/clk_sel_lock.sv
module clk_sel_lock (
    input  logic clk,
    input  logic rst,
    input  logic wdog_cfg_wr,
    input  logic release_lock,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst)               locked <= 1'b0;
        else if (release_lock) locked <= 1'b0;
        else if (wdog_cfg_wr)  locked <= 1'b1;
    end
endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
    import clk_sel_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = RESET_BYTE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_guard,
    input  logic             special_mode,
    input  logic             stop_entry,
    input  logic             osc_ready,
    input  logic             wdog_cfg_wr,
    output logic [REG_W-1:0] rd_data,
    output logic             sel_pll,
    output logic             stop_osc_on,
    output logic             opt_tmra_stop,
    output logic             opt_wdog_stop,
    output logic             tmra_src_osc,
    output logic             wdog_src_osc
);
    ctl_t  ctl_q;
    ctl_t  ctl_d;
    ctl_t  wr_ctl;
    perm_t perm;
    hwf_t  hwf;
    logic  cop_locked;

    clk_sel_wr_perm perm_i (
        .wr_en        (wr_en),
        .wr_guard     (wr_guard),
        .special_mode (special_mode),
        .locked       (cop_locked),
        .perm         (perm)
    );

    clk_sel_hw_force force_i (
        .osc_ready    (osc_ready),
        .stop_entry   (stop_entry),
        .stop_osc_on  (ctl_q.stop_osc_on),
        .wdog_src_now (ctl_q.wdog_src_osc),
        .hwf          (hwf)
    );

    clk_sel_lock lock_i (
        .clk          (clk),
        .rst          (rst),
        .wdog_cfg_wr  (wdog_cfg_wr),
        .release_lock (hwf.release_lock),
        .locked       (cop_locked)
    );

    always_comb begin
        wr_ctl = byte_to_ctl(wr_data);
        ctl_d  = ctl_q;
        if (perm.any_ok) begin
            ctl_d.sel_pll       = wr_ctl.sel_pll;
            ctl_d.stop_osc_on   = wr_ctl.stop_osc_on;
            ctl_d.opt_tmra_stop = wr_ctl.opt_tmra_stop;
            ctl_d.opt_wdog_stop = wr_ctl.opt_wdog_stop;
            ctl_d.tmra_src_osc  = wr_ctl.tmra_src_osc;
        end
        if (perm.wdog_src_ok) ctl_d.wdog_src_osc = wr_ctl.wdog_src_osc;
        if (hwf.force_pll)      ctl_d.sel_pll      = 1'b1;
        if (hwf.clear_wdog_src) ctl_d.wdog_src_osc = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= byte_to_ctl(RESET_VAL);
        else     ctl_q <= ctl_d;
    end

    assign rd_data       = ctl_to_byte(ctl_q);
    assign sel_pll       = ctl_q.sel_pll;
    assign stop_osc_on   = ctl_q.stop_osc_on;
    assign opt_tmra_stop = ctl_q.opt_tmra_stop;
    assign opt_wdog_stop = ctl_q.opt_wdog_stop;
    assign tmra_src_osc  = ctl_q.tmra_src_osc;
    assign wdog_src_osc  = ctl_q.wdog_src_osc;
endmodule

// File: rtl/clk_sel_ctrl_chk.sv
module clk_sel_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_guard,
    input logic       special_mode,
    input logic       stop_entry,
    input logic       osc_ready,
    input logic [7:0] rd_data,
    input logic       sel_pll,
    input logic       stop_osc_on,
    input logic       wdog_src_osc,
    input logic       locked
);
    // R2
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[5:4] == 2'b00);

    // R3
    guard_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_guard && osc_ready && !(stop_entry && !stop_osc_on)) |=> $stable(rd_data));

    // R7
    osc_down_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_ready |=> (sel_pll && !wdog_src_osc));

    // R8
    full_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_entry && !stop_osc_on) |=> (sel_pll && !wdog_src_osc));

    // R5
    wdog_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !special_mode && osc_ready && !(stop_entry && !stop_osc_on))
        |=> $stable(wdog_src_osc));
endmodule

bind clk_sel_ctrl clk_sel_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_guard     (wr_guard),
    .special_mode (special_mode),
    .stop_entry   (stop_entry),
    .osc_ready    (osc_ready),
    .rd_data      (rd_data),
    .sel_pll      (sel_pll),
    .stop_osc_on  (stop_osc_on),
    .wdog_src_osc (wdog_src_osc),
    .locked       (cop_locked)
);

// File: tb/clk_sel_ctrl_tb_top.sv
module clk_sel_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_guard = 1'b0;
    logic       special_mode = 1'b0;
    logic       stop_entry = 1'b0;
    logic       osc_ready = 1'b1;
    logic       wdog_cfg_wr = 1'b0;
    logic [7:0] rd_data;
    logic       sel_pll, stop_osc_on, opt_tmra_stop, opt_wdog_stop, tmra_src_osc, wdog_src_osc;

    int  vectors = 0;
    int  misses = 0;
    bit  done = 1'b0;
    logic [7:0] m_reg;
    logic       m_lock;

    always #10 clk = ~clk;

    clk_sel_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_guard(wr_guard),
        .special_mode(special_mode), .stop_entry(stop_entry), .osc_ready(osc_ready),
        .wdog_cfg_wr(wdog_cfg_wr), .rd_data(rd_data), .sel_pll(sel_pll),
        .stop_osc_on(stop_osc_on), .opt_tmra_stop(opt_tmra_stop),
        .opt_wdog_stop(opt_wdog_stop), .tmra_src_osc(tmra_src_osc),
        .wdog_src_osc(wdog_src_osc)
    );

    // Expected {lock, register} after one edge, from the requirements.
    function automatic logic [8:0] model_next(input logic [7:0] r, input logic lk,
            input logic we, input logic [7:0] d, input logic g, input logic sp,
            input logic st, input logic osc, input logic wd);
        logic [7:0] n;
        logic down, nl;
        n = r;
        down = !osc || (st && !r[6]);
        if (we && !g) begin
            n[7] = d[7]; n[6] = d[6]; n[3] = d[3]; n[2] = d[2]; n[1] = d[1];
            if (sp || !lk) n[0] = d[0];
        end
        if (down) begin n[7] = 1'b1; n[0] = 1'b0; end
        n[5:4] = 2'b00;
        if (down && r[0]) nl = 1'b0;
        else if (wd)      nl = 1'b1;
        else              nl = lk;
        return {nl, n};
    endfunction

    task automatic check(input string tag);
        logic [5:0] pins, exp_pins;
        pins = {sel_pll, stop_osc_on, opt_tmra_stop, opt_wdog_stop, tmra_src_osc, wdog_src_osc};
        exp_pins = {m_reg[7], m_reg[6], m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
        vectors++;
        if (rd_data !== m_reg || pins !== exp_pins) begin
            misses++;
            $display("FAIL %s: rd_data=%02h pins=%06b expected rd_data=%02h pins=%06b",
                     tag, rd_data, pins, m_reg, exp_pins);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] d, input logic g, input logic sp,
                        input logic st, input logic osc, input logic wd, input string tag);
        logic [8:0] nx;
        wr_en = we; wr_data = d; wr_guard = g; special_mode = sp;
        stop_entry = st; osc_ready = osc; wdog_cfg_wr = wd;
        nx = model_next(m_reg, m_lock, we, d, g, sp, st, osc, wd);
        @(posedge clk);
        @(negedge clk);
        m_lock = nx[8];
        m_reg = nx[7:0];
        check(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0143));
        m_reg = 8'h80; m_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset value");
        //   we  data   grd spc stp osc wd
        step(1, 8'hFF, 0, 0, 0, 1, 0, "R2 R10 write all ones");
        step(1, 8'h00, 1, 0, 0, 1, 0, "R3 guarded write");
        step(1, 8'h00, 0, 0, 0, 1, 0, "R4 clear pll with osc up");
        step(1, 8'h01, 0, 0, 0, 0, 0, "R9 write races osc down");
        step(1, 8'h00, 0, 0, 0, 0, 0, "R4 clear pll with osc down");
        step(1, 8'h01, 0, 0, 0, 1, 0, "R5 set wdog src unlocked");
        step(0, 8'h00, 0, 0, 0, 1, 1, "R5 lock pulse");
        step(1, 8'h00, 0, 0, 0, 1, 0, "R5 locked bit0 holds");
        step(1, 8'h06, 0, 0, 0, 1, 0, "R5 other bits free when locked");
        step(1, 8'h00, 0, 1, 0, 1, 0, "R6 special clears locked bit0");
        step(1, 8'h01, 0, 1, 0, 1, 0, "R6 special sets locked bit0");
        step(0, 8'h00, 0, 0, 0, 0, 0, "R7 osc down clears and releases");
        step(1, 8'h00, 0, 0, 0, 1, 0, "R7 pll cleared after recovery");
        step(1, 8'h01, 0, 0, 0, 1, 0, "R7 bit0 writable after release");
        step(0, 8'h00, 0, 0, 1, 1, 0, "R8 full stop forces");
        step(1, 8'h41, 0, 0, 0, 1, 0, "R8 keep osc in stop");
        step(0, 8'h00, 0, 0, 1, 1, 0, "R8 pseudo stop no force");
        step(1, 8'h00, 0, 0, 1, 1, 0, "R9 write with pseudo stop");
        step(1, 8'h0F, 0, 0, 1, 1, 0, "R9 write races full stop");
        step(1, 8'h30, 0, 1, 0, 1, 0, "R2 unimplemented bits read zero");
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[2:0] != 3'd0 && r[3], 8'($urandom), r[7:4] < 4'd3, r[11:8] < 4'd4,
                 r[15:12] < 4'd2, r[19:16] > 4'd1, r[23:20] == 4'd0, "R10 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule